// File: doc/BRIEF.md
# Mux-Scan Chain with Test Sequencer

This block is a small sequential circuit of `LEN` state flip-flops around a fixed next-state function. The flip-flops are built as multiplexed-D scan cells and joined into one chain. In mission mode the circuit runs from its functional inputs. A one-cycle pulse on `test_start` hands control to a built-in sequencer. The sequencer applies `pat_count` stored-state patterns. For each pattern it shifts the state in serially, spends one functional clock capturing the next state, and then shifts the response out. The unload of one response uses the same cycles as the load of the next pattern.

The next-state function is as follows. Cell 0 takes `s[LEN-1] ^ s[0] ^ func_in[0]`. Every other cell i takes `s[i-1] ^ func_in[i]`. The functional outputs `func_out` show the cell contents directly. Two shared-bus driver enables come from the state: `drv_en[0] = s[0]` and `drv_en[1] = s[1] & ~s[0]`.

Shifting must not disturb the chain. For that reason, the asynchronous clear `clr_n` is blocked while shifting, and both driver enables are forced off.

The sequencer has four states:
- IDLE is mission mode.
- SHIFT is test mode, with the shift counter running 0..LEN-1.
- CAPTURE is a single functional clock.
- DONE is a one-cycle end marker.

It has five transitions:
- **start**: IDLE to SHIFT on `test_start`.
- **load end**: SHIFT to CAPTURE after LEN shifts while patterns remain.
- **resume**: CAPTURE to SHIFT.
- **final unload**: SHIFT to DONE after LEN shifts when all patterns are captured.
- **return**: DONE to IDLE.

Top module: `scan_wrap_top`

## Requirements
- R1: While reset is held and directly after it, `func_out` is 0, and `scan_en`, `test_busy` and `test_done` are 0.
- R2: In IDLE, each clock loads `func_out` with the next-state function of the current `func_out` and `func_in`.
- R3: Driving `clr_n` low outside shifting clears all cells to 0 at once, without waiting for a clock.
- R4: In the cycle after a `test_start` pulse in IDLE, `scan_en` is 1. Each shift clock moves `scan_in` into cell 0 and cell i-1 into cell i. `scan_out` always shows cell LEN-1, so the bit shifted in first ends in cell LEN-1.
- R5: After each pass of LEN shifts, if patterns remain, exactly one cycle follows with `scan_en` = 0. In that cycle `func_out` equals the pattern just loaded, and the clock that ends it captures the next-state function into the chain.
- R6: During the pass that loads pattern j+1 (or the final unload pass), `scan_out` shows the captured response of pattern j, starting with cell LEN-1.
- R7: A run with `pat_count` = P spends exactly (P+1)·LEN cycles with `scan_en` = 1. After them, `test_done` is 1 for one cycle, then the block is back in IDLE.
- R8: A low `clr_n` during a shift cycle has no effect; the shifted data arrive intact.
- R9: Both `drv_en` bits are 0 in every shift cycle. Outside shifting they follow the state as defined above, and at most one is ever 1.
- R10: `pat_count` is sampled only at start. A `test_start` pulse or a `pat_count` change during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n | input | 1 | Active-low asynchronous clear of the state cells, blocked while shifting |
| func_in | input | LEN | Functional inputs |
| func_out | output | LEN | Functional outputs (cell contents) |
| drv_en | output | 2 | Shared-bus driver enables |
| test_start | input | 1 | One-cycle pulse that starts a scan run |
| pat_count | input | PCW | Number of patterns for the run |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from cell LEN-1 |
| scan_en | output | 1 | High in shift cycles |
| test_busy | output | 1 | High whenever the sequencer is out of IDLE |
| test_done | output | 1 | One-cycle end-of-run marker |

## Verification
The assertions assume a few things about the inputs:
- `test_start` is a pulse.
- `clr_n` is released away from clock edges.
- The scan-data and functional inputs are steady around each rising edge.

The stimulus changes every input only on the falling edge, and it raises `clr_n` again at the next falling edge. It draws random patterns, input words and clear glitches from `$urandom` with a fixed seed. It also steers directed cases: zero patterns, clears inside shift passes, and restart attempts with a changed count in mid-run.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_CAPTURE,
        SQ_DONE
    } seq_state_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic arst_n,
    input  logic se,
    input  logic d,
    input  logic si,
    output logic q
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= se ? si : d;
    end
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int LEN = 4,
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [PCW-1:0] pat_count,
    output logic           scan_en,
    output logic           busy,
    output logic           done
);
    import scan_wrap_pkg::*;

    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [PCW-1:0] pass_q, pass_d;
    logic [PCW-1:0] pat_q, pat_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            pass_q  <= '0;
            pat_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pass_q  <= pass_d;
            pat_q   <= pat_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pass_d  = pass_q;
        pat_d   = pat_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = SQ_SHIFT;
                    cnt_d   = '0;
                    pass_d  = '0;
                    pat_d   = pat_count;
                end
            end
            SQ_SHIFT: begin
                if (cnt_q == LAST) begin
                    cnt_d = '0;
                    if (pass_q == pat_q) begin
                        state_d = SQ_DONE;
                    end else begin
                        pass_d  = pass_q + 1'b1;
                        state_d = SQ_CAPTURE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_CAPTURE: state_d = SQ_SHIFT;
            SQ_DONE:    state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scan_en = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            SQ_IDLE:    busy    = 1'b0;
            SQ_SHIFT:   scan_en = 1'b1;
            SQ_CAPTURE: ;
            SQ_DONE:    done    = 1'b1;
            default:    busy    = 1'b0;
        endcase
    end

    // R5
    cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CAPTURE) |=> (state_q == SQ_SHIFT));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DONE) |=> (state_q == SQ_IDLE));
    // R7
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q <= pat_q);
    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |=> $stable(pat_q));
endmodule

// File: rtl/scan_wrap_top.sv
module scan_wrap_top #(
    parameter int LEN = 4,
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic [LEN-1:0] func_in,
    output logic [LEN-1:0] func_out,
    output logic [1:0]     drv_en,
    input  logic           test_start,
    input  logic [PCW-1:0] pat_count,
    input  logic           scan_in,
    output logic           scan_out,
    output logic           scan_en,
    output logic           test_busy,
    output logic           test_done
);
    logic [LEN-1:0] chain_q;
    logic [LEN-1:0] nxt_d;
    logic [LEN-1:0] ser_d;
    logic           se_w;
    logic           cell_arst_n;

    scan_seq #(.LEN(LEN), .PCW(PCW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (test_start),
        .pat_count (pat_count),
        .scan_en   (se_w),
        .busy      (test_busy),
        .done      (test_done)
    );

    // clear is blocked while the chain shifts
    assign cell_arst_n = rst_n & (clr_n | se_w);

    genvar i;
    generate
        for (i = 0; i < LEN; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign nxt_d[i] = chain_q[LEN-1] ^ chain_q[0] ^ func_in[0];
                assign ser_d[i] = scan_in;
            end else begin : g_body
                assign nxt_d[i] = chain_q[i-1] ^ func_in[i];
                assign ser_d[i] = chain_q[i-1];
            end
            scan_cell u_cell (
                .clk    (clk),
                .arst_n (cell_arst_n),
                .se     (se_w),
                .d      (nxt_d[i]),
                .si     (ser_d[i]),
                .q      (chain_q[i])
            );
        end
    endgenerate

    assign func_out = chain_q;
    assign scan_out = chain_q[LEN-1];
    assign scan_en  = se_w;
    assign drv_en   = se_w ? 2'b00 : {chain_q[1] & ~chain_q[0], chain_q[0]};

    // R9
    drv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));
    // R9
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_busy && !test_done && scan_en |-> (drv_en == 2'b00));
    // R8
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !clr_n) |=> (func_out[0] == $past(scan_in)));
    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (scan_out == $past(func_out[LEN-2])));
endmodule

// File: tb/sim_scan_wrap_top.sv
module sim_scan_wrap_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN = 4;
    localparam int PCW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr_n = 1'b1;
    logic [LEN-1:0] func_in = '0;
    logic [LEN-1:0] func_out;
    logic [1:0]     drv_en;
    logic           test_start = 1'b0;
    logic [PCW-1:0] pat_count = '0;
    logic           scan_in = 1'b0;
    logic           scan_out;
    logic           scan_en;
    logic           test_busy;
    logic           test_done;

    int n_chk = 0;
    int n_fail = 0;
    logic [LEN-1:0] pat [0:15];
    logic [LEN-1:0] inp [0:15];

    scan_wrap_top #(.LEN(LEN), .PCW(PCW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .func_in(func_in),
        .func_out(func_out), .drv_en(drv_en), .test_start(test_start),
        .pat_count(pat_count), .scan_in(scan_in), .scan_out(scan_out),
        .scan_en(scan_en), .test_busy(test_busy), .test_done(test_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [LEN-1:0] next_f(input logic [LEN-1:0] s, input logic [LEN-1:0] x);
        logic [LEN-1:0] r;
        r[0] = s[LEN-1] ^ s[0] ^ x[0];
        for (int b = 1; b < LEN; b++) r[b] = s[b-1] ^ x[b];
        return r;
    endfunction

    function automatic logic [1:0] drv_f(input logic [LEN-1:0] s);
        return {s[1] & ~s[0], s[0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_scan(input int P, input bit clr_glitch, input bit start_glitch);
        int shifts = 0;
        int pass = 0;
        int k = 0;
        bit fin = 0;
        logic [LEN-1:0] resp;
        for (int j = 0; j < 16; j++) begin
            pat[j] = LEN'($urandom);
            inp[j] = LEN'($urandom);
        end
        pat_count = PCW'(P);
        test_start = 1'b1;
        @(negedge clk);
        test_start = 1'b0;
        check(scan_en == 1'b1, "R4 scan_en after start", int'(scan_en), 1);
        while (!fin) begin
            if (scan_en) begin
                check(drv_en == 2'b00, "R9 drivers off in shift", int'(drv_en), 0);
                if (pass > 0) begin
                    resp = next_f(pat[pass-1], inp[pass-1]);
                    check(scan_out == resp[LEN-1-k], "R6 unload bit", int'(scan_out), int'(resp[LEN-1-k]));
                end
                scan_in = (pass < P) ? pat[pass][LEN-1-k] : 1'($urandom);
                if (pass < P) func_in = inp[pass];
                clr_n = !(clr_glitch && (k == 1));
                if (start_glitch && k == 2) begin
                    test_start = 1'b1;
                    pat_count = PCW'(P + 3);
                end else begin
                    test_start = 1'b0;
                end
                shifts++;
                k++;
                if (k == LEN) begin
                    k = 0;
                    pass++;
                end
            end else if (test_done) begin
                // R7
                check(shifts == (P + 1) * LEN, "R7 shift cycle total", shifts, (P + 1) * LEN);
                // R10
                check(pass == P + 1, "R10 pass count", pass, P + 1);
                fin = 1;
            end else begin
                clr_n = 1'b1;
                test_start = 1'b0;
                check(func_out == pat[pass-1], "R5 loaded pattern at capture", int'(func_out), int'(pat[pass-1]));
                check(drv_en == drv_f(pat[pass-1]), "R9 functional drivers", int'(drv_en), int'(drv_f(pat[pass-1])));
            end
            @(negedge clk);
        end
        clr_n = 1'b1;
        test_start = 1'b0;
        check(!test_done && !test_busy, "R7 back to idle", int'({test_done, test_busy}), 0);
    endtask

    task automatic run_mission(input int cycles);
        logic [LEN-1:0] m;
        clr_n = 1'b0;
        #1;
        check(func_out == '0, "R3 async clear", int'(func_out), 0);
        @(negedge clk);
        clr_n = 1'b1;
        m = '0;
        for (int c = 0; c < cycles; c++) begin
            func_in = LEN'($urandom);
            @(negedge clk);
            m = next_f(m, func_in);
            check(func_out == m, "R2 mission next state", int'(func_out), int'(m));
            check(scan_out == m[LEN-1], "R4 scan_out is last cell", int'(scan_out), int'(m[LEN-1]));
            check(drv_en == drv_f(m), "R9 functional drivers", int'(drv_en), int'(drv_f(m)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        #2;
        check(func_out == '0 && !scan_en && !test_busy && !test_done, "R1 reset state",
              int'({func_out, scan_en, test_busy, test_done}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scan_en && !test_busy && !test_done, "R1 after reset",
              int'({scan_en, test_busy, test_done}), 0);
        run_mission(20);
        run_scan(1, 1'b0, 1'b0);
        run_scan(3, 1'b1, 1'b0);   // R8 clear pulses inside shift
        run_scan(0, 1'b0, 1'b0);
        run_scan(5, 1'b0, 1'b1);   // R10 restart attempt mid-run
        run_mission(12);
        for (int t = 0; t < 4; t++) begin
            run_scan(int'($urandom_range(1, 12)), 1'($urandom), 1'($urandom));
            @(negedge clk);
        end
        run_mission(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule